// File: doc/BRIEF.md
# Multi-Word Flash Burst Programmer

This block takes one burst-program command and streams up to a parameterised number of consecutive 32-bit words toward a flash word-write port. Software loads four holding slots before it triggers the burst. The slots form two halves: slots 0 and 1 are the low half, and slots 2 and 3 are the high half. Each half has its own pending status. While the engine drains one half, software can reload the other. The engine takes slots in the order 0, 1, 2, 3 and then wraps back to slot 0. The address advances by four bytes for each word.

A burst stops in any of three cases: the word limit is reached, the next word would start a new flash page, or a half completes while the other half has not been reloaded. When a refill was late, software reads the progress address and clears its low four bits. It then reloads the slots and triggers again from that 16-byte boundary. A separate overall busy flag stays set until the flash array reports idle after the burst.

Top module: `mpb_burst_prog`

## Requirements
- R1: After reset, mp_busy, isp_busy, fail, fl_req, pend_lo and pend_hi are all zero.
- R2: A write to slot 1 sets both bits of pend_lo, and a write to slot 3 sets both bits of pend_hi. A write to slot 0 or slot 2 alone leaves both pending fields unchanged.
- R3: A write to a slot whose half has its pending bits set is ignored, and the slot keeps its earlier value.
- R4: A trigger whose address has its low four bits at zero starts a burst when isp_busy is low and pend_lo is set. mp_busy reads 1 on the next cycle. Word i is presented at start+4*i with the data of slot i mod 4.
- R5: A half's pending bits clear in the cycle after the flash port accepts its second word.
- R6: A burst ends when a half completes and the other half's pending bits are zero. After the end, prog_addr holds the address of the first word not programmed.
- R7: A burst never programs more than MAX_WORDS words.
- R8: A burst ends after the word that fills the last four bytes of a PAGE_BYTES page.
- R9: A trigger whose address has a nonzero low nibble sets fail and starts nothing. An aligned trigger clears fail.
- R10: A trigger applied while isp_busy is high has no effect.
- R11: isp_busy goes high when a burst starts. It stays high after mp_busy falls, until fl_idle is seen high.
- R12: An aligned trigger with pend_lo clear programs no word, and mp_busy stays low.
- R13: While fl_req is high and fl_ack is low, fl_req, fl_addr and fl_data hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle burst trigger |
| start_addr | input | AW | Byte address of the first word |
| wr_en | input | 1 | Holding-slot write strobe |
| wr_sel | input | 2 | Slot index 0..3 for the write |
| wr_data | input | DW | Word written into the slot |
| fl_req | output | 1 | Flash word write request |
| fl_addr | output | AW | Byte address of the requested word |
| fl_data | output | DW | Data of the requested word |
| fl_ack | input | 1 | Flash accepts the word this cycle |
| fl_idle | input | 1 | Flash array has no operation in progress |
| mp_busy | output | 1 | Burst in progress |
| isp_busy | output | 1 | Burst or trailing flash activity in progress |
| fail | output | 1 | Last trigger had a misaligned address |
| pend_lo | output | 2 | Pending status of slots 0/1 |
| pend_hi | output | 2 | Pending status of slots 2/3 |
| prog_addr | output | AW | Address of the next word to program |

## Verification
The most likely internal faults are a slip in slot order, a lost pending bit, or a wrong stop decision. A slot-order slip shows on fl_data at the very next accepted word. A lost pending bit or a wrong stop decision shows as a burst that is one or more halves too short or too long. That error appears on mp_busy and prog_addr within one cycle of the accept that completes a half. An address fault shows on fl_addr at the accept where it occurs. The word count and the page limit are visible at the last accept of the burst. A wrong isp_busy release shows in the cycle after mp_busy falls, because the flash is still busy then.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
   typedef enum logic {
      MPB_IDLE = 1'b0,
      MPB_RUN  = 1'b1
   } mpb_state_e;

   localparam int unsigned MPB_SLOTS      = 4;
   localparam int unsigned MPB_HALVES     = 2;
   localparam int unsigned MPB_WORD_BYTES = 4;
   localparam int unsigned MPB_ALIGN_BITS = 4;
endpackage

// File: rtl/mpb_hold.sv
module mpb_hold
   import mpb_pkg::*;
#(
   parameter int unsigned DW             = 32,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic [1:0]    rd_sel,
   input  logic [1:0]    clr_half,
   output logic [DW-1:0] rd_data,
   output logic [1:0]    pend
);
   logic [DW-1:0] slot_w [MPB_SLOTS];

   for (genvar h = 0; h < MPB_HALVES; h++) begin : g_half
      logic hit;
      logic pend_q;

      // a half under pending status refuses writes
      assign hit = wr_en && (wr_sel[1] == 1'(h)) && !pend_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               pend_q <= 1'b0;
         else if (clr_half[h])     pend_q <= 1'b0;
         else if (hit && wr_sel[0]) pend_q <= 1'b1;
      end

      assign pend[h] = pend_q;

      for (genvar w = 0; w < 2; w++) begin : g_word
         logic [DW-1:0] word_q;
         logic          load;

         assign load = hit && (wr_sel[0] == 1'(w));

         if (CLEAR_ON_RESET) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)    word_q <= '0;
               else if (load) word_q <= wr_data;
            end
         end else begin : g_nrst
            always_ff @(posedge clk) begin
               if (load) word_q <= wr_data;
            end
         end

         assign slot_w[2*h+w] = word_q;
      end
   end

   assign rd_data = slot_w[rd_sel];
endmodule

// File: rtl/mpb_seq.sv
module mpb_seq
   import mpb_pkg::*;
#(
   parameter int unsigned AW         = 22,
   parameter int unsigned MAX_WORDS  = 64,
   parameter int unsigned PAGE_BYTES = 2048
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic [1:0]    pend,
   input  logic          fl_ack,
   input  logic          fl_idle,
   output logic          run,
   output logic [1:0]    slot,
   output logic [AW-1:0] addr,
   output logic [1:0]    clr_half,
   output logic          isp_busy,
   output logic          fail
);
   localparam int unsigned CNT_W    = $clog2(MAX_WORDS);
   localparam int unsigned PAGE_LSB = $clog2(PAGE_BYTES);

   mpb_state_e    state_q;
   logic [1:0]    slot_q;
   logic [AW-1:0] addr_q;
   logic [CNT_W-1:0] cnt_q;
   logic          isp_q;
   logic          fail_q;

   logic          accept, aligned, ack;
   logic [AW-1:0] next_addr;
   logic          page_end, cnt_last, starve, finish;

   assign accept    = start && !isp_q;
   assign aligned   = (start_addr[MPB_ALIGN_BITS-1:0] == '0);
   assign ack       = (state_q == MPB_RUN) && fl_ack;
   assign next_addr = addr_q + AW'(MPB_WORD_BYTES);
   assign page_end  = (next_addr[PAGE_LSB-1:0] == '0);
   assign cnt_last  = (cnt_q == CNT_W'(MAX_WORDS - 1));
   // completing a half while the other half is still empty
   assign starve    = slot_q[0] && !pend[~slot_q[1]];
   assign finish    = cnt_last || page_end || starve;

   for (genvar h = 0; h < MPB_HALVES; h++) begin : g_clr
      assign clr_half[h] = ack && slot_q[0] && (slot_q[1] == 1'(h));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MPB_IDLE;
         slot_q  <= '0;
         addr_q  <= '0;
         cnt_q   <= '0;
         isp_q   <= 1'b0;
         fail_q  <= 1'b0;
      end else if (accept) begin
         if (aligned) begin
            fail_q <= 1'b0;
            addr_q <= start_addr;
            slot_q <= '0;
            cnt_q  <= '0;
            if (pend[0]) begin
               state_q <= MPB_RUN;
               isp_q   <= 1'b1;
            end
         end else begin
            fail_q <= 1'b1;
         end
      end else begin
         if (ack) begin
            addr_q <= next_addr;
            slot_q <= slot_q + 2'd1;
            cnt_q  <= cnt_q + CNT_W'(1);
            if (finish) state_q <= MPB_IDLE;
         end
         if (isp_q && (state_q == MPB_IDLE) && fl_idle) isp_q <= 1'b0;
      end
   end

   assign run      = (state_q == MPB_RUN);
   assign slot     = slot_q;
   assign addr     = addr_q;
   assign isp_busy = isp_q;
   assign fail     = fail_q;
endmodule

// File: rtl/mpb_burst_prog.sv
module mpb_burst_prog
   import mpb_pkg::*;
#(
   parameter int unsigned DW             = 32,
   parameter int unsigned AW             = 22,
   parameter int unsigned MAX_WORDS      = 64,
   parameter int unsigned PAGE_BYTES     = 2048,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   output logic          fl_req,
   output logic [AW-1:0] fl_addr,
   output logic [DW-1:0] fl_data,
   input  logic          fl_ack,
   input  logic          fl_idle,
   output logic          mp_busy,
   output logic          isp_busy,
   output logic          fail,
   output logic [1:0]    pend_lo,
   output logic [1:0]    pend_hi,
   output logic [AW-1:0] prog_addr
);
   localparam int unsigned PAGE_LSB = $clog2(PAGE_BYTES);

   if (MAX_WORDS < MPB_SLOTS || (MAX_WORDS % MPB_SLOTS) != 0) begin : g_bad_words
      $error("MAX_WORDS must be a nonzero multiple of four");
   end
   if ((1 << PAGE_LSB) != PAGE_BYTES || PAGE_BYTES < 16) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 16");
   end
   if (PAGE_LSB > AW) begin : g_bad_aw
      $error("AW too narrow for one page");
   end
   if (DW < 8) begin : g_bad_dw
      $error("DW too narrow");
   end

   logic [1:0]    pend;
   logic [1:0]    clr_half;
   logic [1:0]    slot;
   logic          run;
   logic [AW-1:0] addr;
   logic [DW-1:0] rd_data;

   mpb_hold #(
      .DW             (DW),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .rd_sel   (slot),
      .clr_half (clr_half),
      .rd_data  (rd_data),
      .pend     (pend)
   );

   mpb_seq #(
      .AW         (AW),
      .MAX_WORDS  (MAX_WORDS),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_addr (start_addr),
      .pend       (pend),
      .fl_ack     (fl_ack),
      .fl_idle    (fl_idle),
      .run        (run),
      .slot       (slot),
      .addr       (addr),
      .clr_half   (clr_half),
      .isp_busy   (isp_busy),
      .fail       (fail)
   );

   assign fl_req    = run;
   assign fl_addr   = addr;
   assign fl_data   = rd_data;
   assign mp_busy   = run;
   assign prog_addr = addr;
   assign pend_lo   = {2{pend[0]}};
   assign pend_hi   = {2{pend[1]}};
endmodule

// File: rtl/mpb_burst_prog_chk.sv
module mpb_burst_prog_chk #(
   parameter int unsigned DW         = 32,
   parameter int unsigned AW         = 22,
   parameter int unsigned MAX_WORDS  = 64,
   parameter int unsigned PAGE_BYTES = 2048
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fl_req,
   input logic          fl_ack,
   input logic [AW-1:0] fl_addr,
   input logic [DW-1:0] fl_data,
   input logic          mp_busy,
   input logic          isp_busy,
   input logic          fail,
   input logic [1:0]    pend_lo,
   input logic [AW-1:0] prog_addr
);
   localparam int unsigned CW = $clog2(MAX_WORDS) + 2;

   logic [CW-1:0] burst_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                burst_n <= '0;
      else if (fl_req && fl_ack) burst_n <= burst_n + CW'(1);
      else if (!mp_busy)         burst_n <= '0;
   end

   always_ff @(posedge clk) begin
      if (rst_n) AST_BURST_LEN: assert (burst_n <= CW'(MAX_WORDS)); // R7
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && !fl_ack |=> fl_req && $stable(fl_addr) && $stable(fl_data)); // R13

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && fl_ack |=> prog_addr == AW'($past(fl_addr) + AW'(4))); // R4

   AST_BUSY_COVER: assert property (@(posedge clk) disable iff (!rst_n)
      mp_busy |-> isp_busy); // R11

   AST_START_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mp_busy) |-> prog_addr[3:0] == 4'd0); // R9

   AST_FAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> !mp_busy); // R9

   AST_PAGE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && fl_ack && (((fl_addr + AW'(4)) & AW'(PAGE_BYTES - 1)) == '0) |=> !mp_busy); // R8

   AST_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && fl_ack && fl_addr[3:2] == 2'd1 |=> pend_lo == 2'b00); // R5
endmodule

bind mpb_burst_prog mpb_burst_prog_chk #(
   .DW         (DW),
   .AW         (AW),
   .MAX_WORDS  (MAX_WORDS),
   .PAGE_BYTES (PAGE_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fl_req    (fl_req),
   .fl_ack    (fl_ack),
   .fl_addr   (fl_addr),
   .fl_data   (fl_data),
   .mp_busy   (mp_busy),
   .isp_busy  (isp_busy),
   .fail      (fail),
   .pend_lo   (pend_lo),
   .prog_addr (prog_addr)
);

// File: tb/mpb_burst_prog_test.sv
module mpb_burst_prog_test;
   localparam int AW   = 22;
   localparam int DW   = 32;
   localparam int MAXW = 64;
   localparam int PAGE = 2048;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [DW-1:0] wr_data = '0;
   logic          fl_req;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_data;
   logic          fl_ack = 1'b0;
   logic          fl_idle = 1'b1;
   logic          mp_busy, isp_busy, fail;
   logic [1:0]    pend_lo, pend_hi;
   logic [AW-1:0] prog_addr;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [AW-1:0] rec_addr [0:127];
   logic [DW-1:0] rec_data [0:127];
   int            rec_n = 0;
   logic [DW-1:0] words [0:127];
   int            fbusy = 0;

   mpb_burst_prog #(.DW(DW), .AW(AW), .MAX_WORDS(MAXW), .PAGE_BYTES(PAGE)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .fl_req(fl_req), .fl_addr(fl_addr), .fl_data(fl_data),
      .fl_ack(fl_ack), .fl_idle(fl_idle),
      .mp_busy(mp_busy), .isp_busy(isp_busy), .fail(fail),
      .pend_lo(pend_lo), .pend_hi(pend_hi), .prog_addr(prog_addr)
   );

   always #4 clk = ~clk;

   // flash model: random accept delay, a few busy cycles after each word
   always @(negedge clk) begin
      if (fl_ack) fbusy = 2 + int'($urandom % 3);
      else if (fbusy > 0) fbusy = fbusy - 1;
      fl_idle = (fbusy == 0);
      if (rst_n && fl_req && fl_idle && ($urandom % 4) != 0) begin
         fl_ack = 1'b1;
         if (rec_n < 128) begin
            rec_addr[rec_n] = fl_addr;
            rec_data[rec_n] = fl_data;
         end
         rec_n = rec_n + 1;
      end else begin
         fl_ack = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_words(input int unsigned sa, input int k);
      int n, rem;
      n = 2 * k;
      if (n > MAXW) n = MAXW;
      rem = int'((PAGE - (sa % PAGE)) / 4);
      if (n > rem) n = rem;
      return n;
   endfunction

   task automatic write_word(input int sel, input logic [DW-1:0] d);
      wr_en = 1'b1;
      wr_sel = 2'(sel);
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_start(input int unsigned sa);
      start = 1'b1;
      start_addr = AW'(sa);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rec_n = 0;
   endtask

   task automatic run_burst(input int unsigned sa, input int k, input bit poke, input string req);
      int n;
      bit starve;
      n = exp_words(sa, k);
      starve = (k >= 1) && (2 * k < ((MAXW < (PAGE - int'(sa % PAGE)) / 4) ? MAXW : (PAGE - int'(sa % PAGE)) / 4));
      for (int i = 0; i < 2 * k && i < 128; i++) words[i] = $urandom;
      do_reset();
      for (int j = 0; j < k && j < 2; j++) begin
         write_word(2 * j, words[2 * j]);
         write_word(2 * j + 1, words[2 * j + 1]);
      end
      if (poke && k >= 1) write_word(0, ~words[0]);
      pulse_start(sa);
      if (n > 0) chk(mp_busy == 1'b1, "R4", "busy after trigger", 64'(mp_busy), 64'd1);
      else       chk(mp_busy == 1'b0, "R12", "no burst on empty half", 64'(mp_busy), 64'd0);
      if (mp_busy) pulse_start(sa + 20);   // ignored while busy (R10)
      for (int j = 2; j < k; j++) begin
         int h = j % 2;
         while (mp_busy && ((h == 1) ? (pend_hi != 0) : (pend_lo != 0))) @(negedge clk);
         if (!mp_busy) break;
         write_word(2 * h, words[2 * j]);
         write_word(2 * h + 1, words[2 * j + 1]);
      end
      while (mp_busy) @(negedge clk);
      if (n > 0) chk(isp_busy == 1'b1, "R11", "isp busy trails burst", 64'(isp_busy), 64'd1);
      while (isp_busy) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(rec_n == n, req, "word count", 64'(rec_n), 64'(n));
      for (int i = 0; i < n && i < rec_n; i++) begin
         chk(rec_addr[i] == AW'(sa + 4 * i), "R4", "word address", 64'(rec_addr[i]), 64'(AW'(sa + 4 * i)));
         chk(rec_data[i] == words[i], (poke && i == 0) ? "R3" : "R4", "word data",
             64'(rec_data[i]), 64'(words[i]));
      end
      chk(prog_addr == AW'(sa + 4 * n), "R6", "progress address", 64'(prog_addr), 64'(AW'(sa + 4 * n)));
      chk(fail == 1'b0, "R10", "stray trigger left fail clear", 64'(fail), 64'd0);
      if (starve)
         chk(pend_lo == 2'b00 && pend_hi == 2'b00, "R5", "pending cleared",
             64'({pend_hi, pend_lo}), 64'd0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(mp_busy == 0 && isp_busy == 0 && fail == 0 && fl_req == 0, "R1", "flags at reset",
          64'({mp_busy, isp_busy, fail, fl_req}), 64'd0);
      chk(pend_lo == 0 && pend_hi == 0, "R1", "pending at reset", 64'({pend_hi, pend_lo}), 64'd0);
      // R2: pending set by second word of each half only
      write_word(0, 32'h1111_0000);
      chk(pend_lo == 2'b00, "R2", "slot0 alone", 64'(pend_lo), 64'd0);
      write_word(1, 32'h1111_0001);
      chk(pend_lo == 2'b11, "R2", "slot1 sets low", 64'(pend_lo), 64'd3);
      write_word(2, 32'h1111_0002);
      chk(pend_hi == 2'b00, "R2", "slot2 alone", 64'(pend_hi), 64'd0);
      write_word(3, 32'h1111_0003);
      chk(pend_hi == 2'b11, "R2", "slot3 sets high", 64'(pend_hi), 64'd3);
      // R9: misaligned trigger
      do_reset();
      pulse_start(32'h104);
      chk(fail == 1'b1, "R9", "misaligned sets fail", 64'(fail), 64'd1);
      chk(mp_busy == 1'b0, "R9", "misaligned no burst", 64'(mp_busy), 64'd0);
      repeat (8) @(negedge clk);
      chk(rec_n == 0, "R9", "misaligned no words", 64'(rec_n), 64'd0);
      pulse_start(32'h200);
      chk(fail == 1'b0, "R9", "aligned clears fail", 64'(fail), 64'd1 - 64'd1);
      chk(mp_busy == 1'b0, "R12", "empty half no burst", 64'(mp_busy), 64'd0);
      repeat (8) @(negedge clk);
      chk(rec_n == 0, "R12", "empty half no words", 64'(rec_n), 64'd0);
      // directed bursts
      run_burst(32'h100, 2, 1'b1, "R6");
      run_burst(32'h200, 1, 1'b0, "R6");
      run_burst(32'h300, 0, 1'b0, "R12");
      run_burst(32'h0, 40, 1'b0, "R7");
      run_burst(32'(PAGE - 32), 10, 1'b0, "R8");
      run_burst(32'(3 * PAGE - 48), 5, 1'b0, "R8");
      // random bursts
      for (int r = 0; r < 14; r++) begin
         int unsigned sa;
         sa = $urandom & 32'h003F_FFF0;
         run_burst(sa, int'($urandom % 36), 1'(r % 5 == 0), "R6");
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule